// File: doc/BRIEF.md
# Quad Configurable PWM/Capture Timer

This block holds four timer subsystems that run side by side, each with its own clock divider and its own operating mode. A subsystem can drive two independent 8-bit pulse-width outputs, or join its two 8-bit halves into one 16-bit pulse-width output. It can also run its 16-bit counter freely and stamp the count into one of two capture registers when an input pin shows a chosen edge. The mode can be changed at run time. Each change restarts that subsystem cleanly and leaves the other three alone.

Configuration arrives on flat per-subsystem buses that a register file elsewhere drives. The per-subsystem fields are the mode, the divider, the period, the duty, and the capture edge selects. A new period or duty is only a request. The running channel adopts it at the end of its current period, so an output never shows a torn cycle. A register file writing through these buses at any time can therefore not corrupt a waveform.

Each channel has one flag output. In the pulse-width modes it marks period ends. In capture mode it shows that a captured value is waiting to be read. A separate overrun output reports a capture that was lost.

Top module: `tmr_quad`

## Requirements
- R1: The four subsystems are independent: the mode, divider, period, duty and edge settings of one never change the outputs or flags of another.
- R2: The divider field of a subsystem gives one counter step every (value+1) clock cycles. A value of 0 steps the counter on every cycle.
- R3: Mode code 0 (split) runs two 8-bit channels:
  - Channel 0 uses period bits [7:0] and duty bits [7:0]; channel 1 uses bits [15:8] of both fields.
  - Each channel counts 0..period and so repeats every period+1 steps.
- R4: Mode code 1 (wide) runs one 16-bit channel on output 0, using the full period and duty fields, with a cycle of period+1 steps. Output 1 is held low.
- R5: A pulse-width output is high while its counter is below the active duty. A duty of 0 gives a constant low, and a duty above the period gives a constant high.
- R6: A changed period or duty is taken into use only when the channel's counter wraps. Until then the current period finishes with the old values.
- R7: In the split and wide modes, a channel's flag is high for exactly one clock cycle each time that channel's counter wraps to zero.
- R8: Mode code 2 (capture) runs a free 16-bit counter stepped by the divider. Each channel has a 2-bit edge select, bits [1:0] for channel 0 and [3:2] for channel 1:
  - Bit 0 of the select enables capture on a rising edge and bit 1 on a falling edge.
  - On a selected edge the channel latches the counter value. Edges that are not selected are ignored.
- R9: In capture mode a channel's flag goes high with a capture and stays high until that channel's acknowledge is pulsed.
- R10: A capture that arrives while the flag is still high, with no acknowledge in the same cycle, sets the channel's overrun output. The overrun output stays set until acknowledged. Overrun is only ever set in capture mode.
- R11: Mode code 3 stops the subsystem with both outputs low. Any mode change restarts the counters and the divider at zero, loads period and duty directly, and clears the capture flags.
- R12: After reset every output, flag, overrun and capture value is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mode | input | NUM_SUB*2 | Mode code per subsystem (0 split, 1 wide, 2 capture, 3 stop) |
| cfg_presc | input | NUM_SUB*PRE_W | Clock divider value per subsystem |
| cfg_per | input | NUM_SUB*2*HALF_W | Period request per subsystem |
| cfg_duty | input | NUM_SUB*2*HALF_W | Duty request per subsystem |
| cfg_edge | input | NUM_SUB*4 | Capture edge selects per subsystem |
| cap_in | input | NUM_SUB*2 | Capture inputs, two per subsystem (synchronous to clk) |
| cap_ack | input | NUM_SUB*2 | Capture acknowledge strobes |
| pwm_out | output | NUM_SUB*2 | Pulse-width outputs, two per subsystem |
| irq_flag | output | NUM_SUB*2 | Per-channel event flag |
| cap_ovr | output | NUM_SUB*2 | Per-channel capture overrun |
| cap_val | output | NUM_SUB*2*2*HALF_W | Captured counter values |

## Verification
The bench builds the block with its defaults: four subsystems, an 8-bit divider and 8-bit halves. With these values all three modes and the stop code can run at once in different subsystems, so a fault that leaks between subsystems shows up. A divider of 3 keeps the stretched period short enough to measure over whole periods. A wide period of 299 makes the 16-bit count carry across the half boundary. Captures taken a known number of cycles apart check the free counter by their difference, with no dependence on absolute phase.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic [1:0] {
        TM_SPLIT8 = 2'd0,
        TM_WIDE16 = 2'd1,
        TM_CAPT   = 2'd2,
        TM_STOP   = 2'd3
    } tmr_mode_e;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic [PRE_W-1:0] div_i,
    output logic             tick_o
);
    logic [PRE_W-1:0] cnt_d, cnt_q;
    logic             at_end;

    // A shrinking divider value must still wrap, hence >= rather than ==.
    assign at_end = (cnt_q >= div_i);
    assign tick_o = at_end && !restart_i;

    always_comb begin
        cnt_d = cnt_q + 1'b1;
        if (restart_i || at_end) begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/tmr_capture_chan.sv
module tmr_capture_chan #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             enable_i,
    input  logic [1:0]       edge_sel_i,
    input  logic             sig_i,
    input  logic             ack_i,
    input  logic [CNT_W-1:0] count_i,
    output logic [CNT_W-1:0] value_o,
    output logic             full_o,
    output logic             ovr_o
);
    typedef struct packed {
        logic             prev;
        logic [CNT_W-1:0] val;
        logic             full;
        logic             ovr;
    } cap_state_t;

    cap_state_t st_d, st_q;
    logic       rise, fall, hit;

    assign rise = sig_i && !st_q.prev;
    assign fall = !sig_i && st_q.prev;
    assign hit  = enable_i && ((edge_sel_i[0] && rise) || (edge_sel_i[1] && fall));

    always_comb begin
        st_d      = st_q;
        st_d.prev = sig_i;
        if (clear_i) begin
            st_d.val  = '0;
            st_d.full = 1'b0;
            st_d.ovr  = 1'b0;
        end else begin
            // An acknowledge in the same cycle as a capture means the old value was read.
            st_d.ovr = (hit && st_q.full && !ack_i) || (st_q.ovr && !ack_i);
            if (hit) begin
                st_d.val  = count_i;
                st_d.full = 1'b1;
            end else if (ack_i) begin
                st_d.full = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign value_o = st_q.val;
    assign full_o  = st_q.full;
    assign ovr_o   = st_q.ovr;
endmodule

// File: rtl/tmr_subsys.sv
module tmr_subsys
    import tmr_pkg::*;
#(
    parameter int PRE_W  = 8,
    parameter int HALF_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            mode_i,
    input  logic [PRE_W-1:0]      presc_i,
    input  logic [2*HALF_W-1:0]   per_i,
    input  logic [2*HALF_W-1:0]   duty_i,
    input  logic [3:0]            edge_i,
    input  logic [1:0]            cap_i,
    input  logic [1:0]            ack_i,
    output logic [1:0]            pwm_o,
    output logic [1:0]            irq_o,
    output logic [1:0]            ovr_o,
    output logic [4*HALF_W-1:0]   cap_val_o
);
    localparam int CNT_W = 2 * HALF_W;

    typedef struct packed {
        tmr_mode_e         mode;
        logic [HALF_W-1:0] lo;
        logic [HALF_W-1:0] hi;
        logic [CNT_W-1:0]  per_a;
        logic [CNT_W-1:0]  duty_a;
        logic [1:0]        irq;
    } sub_state_t;

    sub_state_t       s_d, s_q;
    tmr_mode_e        mode_req;
    logic             chg, tick;
    logic [CNT_W-1:0] wide_q;
    logic [1:0]       full;

    assign mode_req = tmr_mode_e'(mode_i);
    assign chg      = (mode_req != s_q.mode);
    assign wide_q   = {s_q.hi, s_q.lo};

    tmr_prescaler #(.PRE_W(PRE_W)) u_presc (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (chg),
        .div_i     (presc_i),
        .tick_o    (tick)
    );

    always_comb begin
        s_d     = s_q;
        s_d.irq = '0;
        if (chg) begin
            s_d.mode   = mode_req;
            s_d.lo     = '0;
            s_d.hi     = '0;
            s_d.per_a  = per_i;
            s_d.duty_a = duty_i;
        end else if (tick) begin
            case (s_q.mode)
                TM_SPLIT8: begin
                    if (s_q.lo >= s_q.per_a[HALF_W-1:0]) begin
                        s_d.lo                     = '0;
                        s_d.per_a[HALF_W-1:0]      = per_i[HALF_W-1:0];
                        s_d.duty_a[HALF_W-1:0]     = duty_i[HALF_W-1:0];
                        s_d.irq[0]                 = 1'b1;
                    end else begin
                        s_d.lo = s_q.lo + 1'b1;
                    end
                    if (s_q.hi >= s_q.per_a[CNT_W-1:HALF_W]) begin
                        s_d.hi                     = '0;
                        s_d.per_a[CNT_W-1:HALF_W]  = per_i[CNT_W-1:HALF_W];
                        s_d.duty_a[CNT_W-1:HALF_W] = duty_i[CNT_W-1:HALF_W];
                        s_d.irq[1]                 = 1'b1;
                    end else begin
                        s_d.hi = s_q.hi + 1'b1;
                    end
                end
                TM_WIDE16: begin
                    if (wide_q >= s_q.per_a) begin
                        {s_d.hi, s_d.lo} = '0;
                        s_d.per_a        = per_i;
                        s_d.duty_a       = duty_i;
                        s_d.irq[0]       = 1'b1;
                    end else begin
                        {s_d.hi, s_d.lo} = wide_q + 1'b1;
                    end
                end
                TM_CAPT: begin
                    {s_d.hi, s_d.lo} = wide_q + 1'b1;
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.mode <= TM_STOP;
        end else begin
            s_q <= s_d;
        end
    end

    generate
        for (genvar k = 0; k < 2; k++) begin : g_cap
            tmr_capture_chan #(.CNT_W(CNT_W)) u_cap (
                .clk        (clk),
                .rst_n      (rst_n),
                .clear_i    (chg),
                .enable_i   (s_q.mode == TM_CAPT),
                .edge_sel_i (edge_i[2*k +: 2]),
                .sig_i      (cap_i[k]),
                .ack_i      (ack_i[k]),
                .count_i    (wide_q),
                .value_o    (cap_val_o[k*CNT_W +: CNT_W]),
                .full_o     (full[k]),
                .ovr_o      (ovr_o[k])
            );
        end
    endgenerate

    always_comb begin
        pwm_o = '0;
        irq_o = s_q.irq;
        case (s_q.mode)
            TM_SPLIT8: begin
                pwm_o[0] = (s_q.lo < s_q.duty_a[HALF_W-1:0]);
                pwm_o[1] = (s_q.hi < s_q.duty_a[CNT_W-1:HALF_W]);
            end
            TM_WIDE16: begin
                pwm_o[0] = (wide_q < s_q.duty_a);
            end
            TM_CAPT: begin
                irq_o = full;
            end
            default: begin
            end
        endcase
    end
endmodule

// File: rtl/tmr_quad.sv
module tmr_quad #(
    parameter int NUM_SUB = 4,
    parameter int PRE_W   = 8,
    parameter int HALF_W  = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_SUB*2-1:0]          cfg_mode,
    input  logic [NUM_SUB*PRE_W-1:0]      cfg_presc,
    input  logic [NUM_SUB*2*HALF_W-1:0]   cfg_per,
    input  logic [NUM_SUB*2*HALF_W-1:0]   cfg_duty,
    input  logic [NUM_SUB*4-1:0]          cfg_edge,
    input  logic [NUM_SUB*2-1:0]          cap_in,
    input  logic [NUM_SUB*2-1:0]          cap_ack,
    output logic [NUM_SUB*2-1:0]          pwm_out,
    output logic [NUM_SUB*2-1:0]          irq_flag,
    output logic [NUM_SUB*2-1:0]          cap_ovr,
    output logic [NUM_SUB*4*HALF_W-1:0]   cap_val
);
    localparam int CNT_W = 2 * HALF_W;

    generate
        for (genvar s = 0; s < NUM_SUB; s++) begin : g_sub
            tmr_subsys #(.PRE_W(PRE_W), .HALF_W(HALF_W)) u_sub (
                .clk       (clk),
                .rst_n     (rst_n),
                .mode_i    (cfg_mode[2*s +: 2]),
                .presc_i   (cfg_presc[PRE_W*s +: PRE_W]),
                .per_i     (cfg_per[CNT_W*s +: CNT_W]),
                .duty_i    (cfg_duty[CNT_W*s +: CNT_W]),
                .edge_i    (cfg_edge[4*s +: 4]),
                .cap_i     (cap_in[2*s +: 2]),
                .ack_i     (cap_ack[2*s +: 2]),
                .pwm_o     (pwm_out[2*s +: 2]),
                .irq_o     (irq_flag[2*s +: 2]),
                .ovr_o     (cap_ovr[2*s +: 2]),
                .cap_val_o (cap_val[2*CNT_W*s +: 2*CNT_W])
            );
        end
    endgenerate
endmodule

// File: rtl/tmr_quad_chk.sv
module tmr_quad_chk #(
    parameter int NUM_SUB = 4,
    parameter int PRE_W   = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NUM_SUB*2-1:0]     cfg_mode,
    input logic [NUM_SUB*PRE_W-1:0] cfg_presc,
    input logic [NUM_SUB*2-1:0]     pwm_out,
    input logic [NUM_SUB*2-1:0]     irq_flag,
    input logic [NUM_SUB*2-1:0]     cap_ovr
);
    logic seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
        end else begin
            seen_q <= 1'b1;
        end
    end

    generate
        for (genvar g = 0; g < NUM_SUB; g++) begin : g_chk
            // R11: a stop request leaves both outputs low from the next cycle
            assert_stop_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_mode[2*g +: 2] == 2'd3) |=> (pwm_out[2*g +: 2] == 2'b00));

            // R4: wide mode keeps output 1 low
            assert_wide_out1_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_mode[2*g +: 2] == 2'd1) |=> !pwm_out[2*g+1]);

            // R10: overrun only rises when a capture was already waiting
            assert_ovr_after_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
                (seen_q && $rose(cap_ovr[2*g])) |-> $past(irq_flag[2*g]));

            // R10: overrun only exists in capture mode
            assert_ovr_capt_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
                (seen_q && cap_ovr[2*g+1]) |-> ($past(cfg_mode[2*g +: 2]) == 2'd2));

            // R7: with a divider above zero, the split-mode flag lasts a single cycle
            for (genvar c = 0; c < 2; c++) begin : g_ch
                assert_irq_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
                    (seen_q && cfg_mode[2*g +: 2] == 2'd0 && $past(cfg_mode[2*g +: 2]) == 2'd0
                     && cfg_presc[PRE_W*g +: PRE_W] != '0
                     && $past(cfg_presc[PRE_W*g +: PRE_W]) != '0
                     && irq_flag[2*g+c]) |=> !irq_flag[2*g+c]);
            end
        end
    endgenerate
endmodule

bind tmr_quad tmr_quad_chk #(.NUM_SUB(NUM_SUB), .PRE_W(PRE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_mode  (cfg_mode),
    .cfg_presc (cfg_presc),
    .pwm_out   (pwm_out),
    .irq_flag  (irq_flag),
    .cap_ovr   (cap_ovr)
);

// File: tb/tmr_quad_bench.sv
`timescale 1ns/1ps
module tmr_quad_bench;
    localparam int NS = 4;
    localparam int PW = 8;
    localparam int HW = 8;
    localparam int CW = 2 * HW;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [NS*2-1:0]     cfg_mode = '1;
    logic [NS*PW-1:0]    cfg_presc = '0;
    logic [NS*CW-1:0]    cfg_per = '0;
    logic [NS*CW-1:0]    cfg_duty = '0;
    logic [NS*4-1:0]     cfg_edge = '0;
    logic [NS*2-1:0]     cap_in = '0;
    logic [NS*2-1:0]     cap_ack = '0;
    logic [NS*2-1:0]     pwm_out;
    logic [NS*2-1:0]     irq_flag;
    logic [NS*2-1:0]     cap_ovr;
    logic [NS*2*CW-1:0]  cap_val;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    tmr_quad #(.NUM_SUB(NS), .PRE_W(PW), .HALF_W(HW)) u_tmr_quad (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_presc(cfg_presc),
        .cfg_per(cfg_per), .cfg_duty(cfg_duty), .cfg_edge(cfg_edge),
        .cap_in(cap_in), .cap_ack(cap_ack), .pwm_out(pwm_out),
        .irq_flag(irq_flag), .cap_ovr(cap_ovr), .cap_val(cap_val)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic setup(input int s, input int mode, input int presc, input int per, input int duty);
        cfg_mode[2*s +: 2]    = mode[1:0];
        cfg_presc[PW*s +: PW] = presc[PW-1:0];
        cfg_per[CW*s +: CW]   = per[CW-1:0];
        cfg_duty[CW*s +: CW]  = duty[CW-1:0];
    endtask

    task automatic measure(input int idx, input int cycles, output int hi, output int ev);
        hi = 0;
        ev = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            hi += int'(pwm_out[idx]);
            ev += int'(irq_flag[idx]);
        end
    endtask

    function automatic int capv(input int idx);
        return int'(cap_val[CW*idx +: CW]);
    endfunction

    task automatic t_reset();
        check("R12", "pwm after reset", int'(pwm_out), 0);
        check("R12", "flags after reset", int'(irq_flag), 0);
        check("R12", "overrun after reset", int'(cap_ovr), 0);
        check("R12", "capture values after reset", int'(cap_val != '0), 0);
    endtask

    task automatic t_concurrent();
        int hi, ev;
        @(negedge clk);
        setup(0, 0, 0, {8'd7, 8'd3}, {8'd5, 8'd1});
        setup(1, 0, 3, 3, 1);
        setup(2, 1, 0, 299, 100);
        repeat (320) @(negedge clk);
        measure(0, 32, hi, ev);
        check("R3", "split ch0 high cycles", hi, 8);
        check("R7", "split ch0 period flags", ev, 8);
        measure(1, 32, hi, ev);
        check("R3", "split ch1 high cycles", hi, 20);
        check("R7", "split ch1 period flags", ev, 4);
        measure(2, 64, hi, ev);
        check("R2", "divided ch high cycles", hi, 16);
        check("R2", "divided ch period flags", ev, 4);
        measure(4, 600, hi, ev);
        check("R4", "wide high cycles", hi, 200);
        check("R4", "wide period flags", ev, 2);
        measure(5, 600, hi, ev);
        check("R4", "wide output 1 high cycles", hi, 0);
        measure(6, 40, hi, ev);
        check("R1", "stopped neighbour output", hi + ev, 0);
    endtask

    task automatic t_extremes();
        int hi, ev;
        cfg_duty[7:0] = 8'd0;
        repeat (10) @(negedge clk);
        measure(0, 32, hi, ev);
        check("R5", "duty zero high cycles", hi, 0);
        cfg_duty[7:0] = 8'd9;
        repeat (10) @(negedge clk);
        measure(0, 32, hi, ev);
        check("R5", "duty above period high cycles", hi, 32);
    endtask

    task automatic t_dbuf();
        int hi, ev;
        cfg_per[7:0]  = 8'd9;
        cfg_duty[7:0] = 8'd5;
        repeat (30) @(negedge clk);
        do @(negedge clk); while (!irq_flag[0]);
        cfg_duty[7:0] = 8'd0;
        hi = 0;
        for (int i = 0; i < 4; i++) begin
            hi += int'(pwm_out[0]);
            @(negedge clk);
        end
        check("R6", "old duty kept to period end", hi, 4);
        while (!irq_flag[0]) @(negedge clk);
        measure(0, 10, hi, ev);
        check("R6", "new duty after wrap", hi, 0);
    endtask

    task automatic t_stop_restart();
        int hi, ev;
        int exp_pwm [5] = '{1, 1, 0, 0, 1};
        int exp_irq [5] = '{0, 0, 0, 0, 1};
        @(negedge clk);
        cfg_mode[1:0] = 2'd3;
        @(negedge clk);
        measure(0, 20, hi, ev);
        check("R11", "stop ch0 activity", hi + ev, 0);
        measure(1, 20, hi, ev);
        check("R11", "stop ch1 activity", hi + ev, 0);
        setup(0, 0, 0, 3, 2);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check("R11", $sformatf("restart pwm step %0d", i), int'(pwm_out[0]), exp_pwm[i]);
            check("R11", $sformatf("restart flag step %0d", i), int'(irq_flag[0]), exp_irq[i]);
        end
    endtask

    task automatic t_capture();
        int v1, v2, v3;
        @(negedge clk);
        setup(3, 2, 0, 0, 0);
        cfg_edge[12 +: 4] = 4'b1001;
        repeat (5) @(negedge clk);
        cap_in[6] = 1'b1;
        @(negedge clk);
        check("R9", "flag after rising capture", int'(irq_flag[6]), 1);
        v1 = capv(6);
        cap_ack[6] = 1'b1;
        @(negedge clk);
        cap_ack[6] = 1'b0;
        check("R9", "flag cleared by ack", int'(irq_flag[6]), 0);
        cap_in[6] = 1'b0;
        repeat (5) @(negedge clk);
        check("R8", "falling edge ignored on rise-only ch", int'(irq_flag[6]), 0);
        repeat (30) @(negedge clk);
        cap_in[6] = 1'b1;
        @(negedge clk);
        check("R8", "second rising capture flag", int'(irq_flag[6]), 1);
        v2 = capv(6);
        check("R8", "capture spacing", (v2 - v1) & 16'hFFFF, 37);
        cap_ack[6] = 1'b1;
        @(negedge clk);
        cap_ack[6] = 1'b0;
        cap_in[7] = 1'b1;
        @(negedge clk);
        check("R8", "rising ignored on fall-only ch", int'(irq_flag[7]), 0);
        cap_in[7] = 1'b0;
        @(negedge clk);
        check("R8", "falling capture flag", int'(irq_flag[7]), 1);
        v1 = capv(7);
        cap_in[7] = 1'b1;
        @(negedge clk);
        cap_in[7] = 1'b0;
        @(negedge clk);
        check("R10", "overrun set", int'(cap_ovr[7]), 1);
        v3 = capv(7);
        check("R10", "latest value kept", (v3 - v1) & 16'hFFFF, 2);
        check("R1", "ch0 overrun untouched", int'(cap_ovr[6]), 0);
        cap_ack[7] = 1'b1;
        @(negedge clk);
        cap_ack[7] = 1'b0;
        check("R10", "overrun cleared by ack", int'(cap_ovr[7]), 0);
        check("R9", "flag cleared with overrun", int'(irq_flag[7]), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_concurrent();
        t_extremes();
        t_dbuf();
        t_stop_restart();
        t_capture();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #400000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule